// File: doc/BRIEF.md
# Two-Wire Converter Readout Controller

This block is the device-side digital controller of a single-channel delta-sigma converter. The host has two signals: a serial clock input and one output line. The output line first acts as a data-ready flag and then carries the data. A conversion engine delivers 18-bit results through a one-cycle valid strobe. A calibration engine is started and finished through a request level and a done pulse.

The host controls everything through the number of serial clock pulses in a frame and the level at which it leaves the clock. Pulses 1 to 18 shift the result out. The 25th pulse releases the line. A 26th pulse starts a self-calibration. Holding the clock high for long enough puts the block to sleep. The serial clock is asynchronous. It is brought into the system clock domain through a two-stage synchronizer, and all edge and level decisions use the synchronized copy.

Top module: `adc_readout_ctrl`

## Requirements
- R1: From reset, `rdy_dout` is 1, `conv_run` is 0 and `cal_req` is 1. Start-up always runs one calibration before any result is offered.
- R2: A `cal_done` pulse during calibration moves the block to converting (`conv_run`=1, `cal_req`=0). In that state a `res_valid` strobe latches `res_data` and drives `rdy_dout` low on the next clock.
- R3: Serial clock rising edges 1 to 18 of a frame present the latched word on `rdy_dout` one bit per edge, bit 17 (the sign of the two's-complement value) first and bit 0 last. Each bit is applied three system clocks after the rising edge reaches the pin.
- R4: Between rising edges the line holds the last bit presented. Rising edges 19 to 24 each drive 0.
- R5: The 25th rising edge of a frame drives `rdy_dout` back to 1.
- R6: After a 26th rising edge, the following falling edge starts calibration (`cal_req`=1, `conv_run`=0, line high). `rdy_dout` goes low again only when a result strobed after `cal_done` is latched.
- R7: A result that has not been read is replaced by a newer strobe. The next frame shifts out only the newer word, starting again from bit 17.
- R8: While a result frame is pending, a serial clock held high for `SLEEP_CYC` consecutive system clocks enters sleep (`rdy_dout`=1, `conv_run`=0, `cal_req`=0). This applies even when the word is partly read. Shorter high phases do not enter sleep.
- R9: A falling serial clock edge during sleep returns the block to converting with no calibration, with the line high until the next result.
- R10: If sleep was entered after the 26th rising edge, the falling edge that ends sleep starts a calibration instead.
- R11: `res_valid` strobes during calibration or sleep are ignored: the line stays high.
- R12: Serial clock rising edges when no result is pending leave the line high and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | Host serial clock, asynchronous to clk |
| res_valid | input | 1 | One-cycle strobe: a conversion result is on res_data |
| res_data | input | 18 | Conversion result, two's complement |
| cal_done | input | 1 | One-cycle pulse: calibration finished |
| cal_req | output | 1 | High while a calibration is requested or running |
| conv_run | output | 1 | High while the conversion engine should run |
| rdy_dout | output | 1 | Combined ready flag and serial data line |

## Verification
The frame pattern is tried with several values. A mixed word shows bit order. A negative word and a word with a single low bit show sign handling and shifts that drop or duplicate a bit. Frames are cut at different lengths to separate the effects of pulse 18, 24, 25 and 26. Two sleep patterns are used: a long high phase in the middle of a partly read word, and a long high phase after the 26th pulse. Together with a near-miss high phase and strobes during calibration and sleep, these tell a plain wake apart from a calibrating wake and a real sleep request from an ordinary clock phase. A behavioural model of the pin compares all three outputs on every clock.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_CAL   = 2'd0,
    ST_RUN   = 2'd1,
    ST_SLEEP = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/sclk_sync_edge.sv
module sclk_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q, chain_n;
  logic              prev_q, prev_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], pin};
    prev_n  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_n;
      prev_q  <= prev_n;
    end
  end

  assign lvl  = chain_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  // a detected edge cannot repeat on the next clock (supports R3)
  assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/sclk_hold_timer.sv
module sclk_hold_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    if (!lvl)                        cnt_n = '0;
    else if (cnt_q == CW'(LIMIT))    cnt_n = cnt_q;
    else                             cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign hit = lvl && (cnt_q == CW'(LIMIT - 1));

  assert_hold_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/result_shifter.sv
module result_shifter #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] word_q, word_n;

  always_comb begin
    word_n = word_q;
    if (load)       word_n = din;
    else if (shift) word_n = {word_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_n;
  end

  assign msb = word_q[W-1];

  assert_load_replaces_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (word_q == $past(din)));
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W    = 18,
  parameter int PAD_PULSE = 6,
  parameter int SLEEP_CYC = 64,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              cal_done,
  output logic              cal_req,
  output logic              conv_run,
  output logic              rdy_dout
);
  localparam int REL_IDX = DATA_W + PAD_PULSE;   // 25th edge index (0-based count)
  localparam int CAL_IDX = REL_IDX + 1;          // 26th edge
  localparam int CNT_MAX = CAL_IDX + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic s_lvl, s_rise, s_fall, hold_hit, sh_msb, sh_load, sh_shift;

  ctl_state_t    state_q, state_n;
  logic          dv_q, dv_n, p26_q, p26_n, wcal_q, wcal_n, dout_q, dout_n;
  logic [CW-1:0] cnt_q, cnt_n;

  sclk_sync_edge #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(sclk), .lvl(s_lvl), .rise(s_rise), .fall(s_fall));

  sclk_hold_timer #(.LIMIT(SLEEP_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .lvl(s_lvl), .hit(hold_hit));

  result_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .din(res_data),
    .shift(sh_shift), .msb(sh_msb));

  always_comb begin
    state_n  = state_q;
    dv_n     = dv_q;
    p26_n    = p26_q;
    wcal_n   = wcal_q;
    cnt_n    = cnt_q;
    dout_n   = dout_q;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_CAL: begin
        dout_n = 1'b1;
        if (cal_done) begin
          state_n = ST_RUN;
          dv_n    = 1'b0;
          p26_n   = 1'b0;
          cnt_n   = '0;
        end
      end
      ST_SLEEP: begin
        dout_n = 1'b1;
        if (s_fall) begin
          state_n = wcal_q ? ST_CAL : ST_RUN;
          wcal_n  = 1'b0;
        end
      end
      default: begin
        if (dv_q && hold_hit) begin
          state_n = ST_SLEEP;
          wcal_n  = p26_q;
          dv_n    = 1'b0;
          p26_n   = 1'b0;
          cnt_n   = '0;
          dout_n  = 1'b1;
        end else if (res_valid) begin
          sh_load = 1'b1;
          dv_n    = 1'b1;
          p26_n   = 1'b0;
          cnt_n   = '0;
          dout_n  = 1'b0;
        end else if (dv_q && s_rise) begin
          if (cnt_q < CW'(DATA_W)) begin
            dout_n   = sh_msb;
            sh_shift = 1'b1;
          end else if (cnt_q < CW'(REL_IDX)) begin
            dout_n = 1'b0;
          end else if (cnt_q == CW'(REL_IDX)) begin
            dout_n = 1'b1;
          end else if (cnt_q == CW'(CAL_IDX)) begin
            p26_n = 1'b1;
          end
          if (cnt_q != CW'(CNT_MAX)) cnt_n = cnt_q + 1'b1;
        end else if (dv_q && p26_q && s_fall) begin
          state_n = ST_CAL;
          dv_n    = 1'b0;
          p26_n   = 1'b0;
          cnt_n   = '0;
          dout_n  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CAL;
      dv_q    <= 1'b0;
      p26_q   <= 1'b0;
      wcal_q  <= 1'b0;
      cnt_q   <= '0;
      dout_q  <= 1'b1;
    end else begin
      state_q <= state_n;
      dv_q    <= dv_n;
      p26_q   <= p26_n;
      wcal_q  <= wcal_n;
      cnt_q   <= cnt_n;
      dout_q  <= dout_n;
    end
  end

  assign cal_req  = (state_q == ST_CAL);
  assign conv_run = (state_q == ST_RUN);
  assign rdy_dout = dout_q;

  assert_latch_pulls_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_run && res_valid && !(dv_q && hold_hit)) |=> !rdy_dout);
  assert_release_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_run && dv_q && s_rise && !res_valid && !hold_hit && cnt_q == CW'(REL_IDX)) |=> rdy_dout);
  assert_sleep_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP) |-> rdy_dout);
  assert_cal_line_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> rdy_dout);
  assert_idle_edges_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_run && !dv_q && !res_valid) |=> (rdy_dout && conv_run));
  assert_wake_cal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SLEEP) && s_fall && wcal_q) |=> cal_req);
endmodule

// File: tb/adc_readout_ctrl_bench.sv
module adc_readout_ctrl_bench;
  localparam int DW = 18;
  localparam int SC = 64;

  logic clk = 1'b0;
  logic rst_n, sclk, res_valid, cal_done;
  logic [DW-1:0] res_data;
  logic cal_req, conv_run, rdy_dout;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  adc_readout_ctrl u_adc_readout_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .res_valid(res_valid),
    .res_data(res_data), .cal_done(cal_done), .cal_req(cal_req),
    .conv_run(conv_run), .rdy_dout(rdy_dout));

  // ---------------- behavioural reference of the pin ----------------
  int     m_mode;          // 0 calibrating, 1 converting, 2 sleeping
  bit     m_pend, m_p26, m_wcal, m_line;
  int     m_edges, m_hi;
  bit     m_word[$];
  bit     h1, h2, h3;

  always @(posedge clk) begin
    bit up, dn, slp;
    if (!rst_n) begin
      m_mode = 0; m_pend = 0; m_p26 = 0; m_wcal = 0; m_line = 1;
      m_edges = 0; m_hi = 0; h1 = 0; h2 = 0; h3 = 0;
      m_word.delete();
    end else begin
      up  = h2 && !h3;
      dn  = !h2 && h3;
      slp = h2 && (m_hi == SC - 1);
      if (m_mode == 0) begin
        if (cal_done) begin m_mode = 1; m_pend = 0; m_p26 = 0; m_edges = 0; end
      end else if (m_mode == 2) begin
        if (dn) begin m_mode = m_wcal ? 0 : 1; m_wcal = 0; end
      end else begin
        if (m_pend && slp) begin
          m_mode = 2; m_wcal = m_p26; m_pend = 0; m_p26 = 0; m_edges = 0; m_line = 1;
        end else if (res_valid) begin
          m_word.delete();
          for (int i = DW - 1; i >= 0; i--) m_word.push_back(res_data[i]);
          m_pend = 1; m_p26 = 0; m_edges = 0; m_line = 0;
        end else if (m_pend && up) begin
          m_edges++;
          if (m_edges <= DW)       m_line = m_word.pop_front();
          else if (m_edges <= 24)  m_line = 0;
          else if (m_edges == 25)  m_line = 1;
          else if (m_edges == 26)  m_p26 = 1;
          if (m_edges > 27) m_edges = 27;
        end else if (m_pend && m_p26 && dn) begin
          m_mode = 0; m_pend = 0; m_p26 = 0; m_edges = 0; m_line = 1;
        end
      end
      if (m_mode != 1) m_line = 1;
      m_hi = h2 ? ((m_hi < SC) ? m_hi + 1 : m_hi) : 0;
      h3 = h2; h2 = h1; h1 = sclk;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(rdy_dout == m_line, "model rdy_dout", rdy_dout, m_line);
      chk(cal_req == (m_mode == 0), "model cal_req", cal_req, m_mode == 0);
      chk(conv_run == (m_mode == 1), "model conv_run", conv_run, m_mode == 1);
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_cal();
    wait_clk(4);
    cal_done = 1'b1; wait_clk(1); cal_done = 1'b0; wait_clk(2);
  endtask

  task automatic give(input logic [DW-1:0] v);
    res_data = v; res_valid = 1'b1; wait_clk(1); res_valid = 1'b0; res_data = '0;
    wait_clk(1);
  endtask

  // one full serial pulse; returns the line sampled late in the high phase
  task automatic pulse(output bit b);
    sclk = 1'b1; wait_clk(6); b = rdy_dout;
    sclk = 1'b0; wait_clk(6);
  endtask

  task automatic pulses(input int n);
    bit d;
    for (int i = 0; i < n; i++) pulse(d);
  endtask

  task automatic read_word(output logic [DW-1:0] v);
    bit d;
    for (int i = DW - 1; i >= 0; i--) begin pulse(d); v[i] = d; end
  endtask

  initial begin
    logic [DW-1:0] got;
    bit d;
    rst_n = 1'b0; sclk = 1'b0; res_valid = 1'b0; cal_done = 1'b0; res_data = '0;
    wait_clk(3);
    chk(rdy_dout == 1 && cal_req == 1 && conv_run == 0, "R1 reset state",
        {rdy_dout, cal_req, conv_run}, 3'b110);
    rst_n = 1'b1;
    wait_clk(3);
    chk(cal_req == 1, "R1 start-up calibration", cal_req, 1);
    finish_cal();
    chk(conv_run == 1 && cal_req == 0, "R2 run after cal_done", {cal_req, conv_run}, 2'b01);

    pulses(3);
    chk(rdy_dout == 1, "R12 idle edges keep line high", rdy_dout, 1);

    give(18'h2A5C3);
    chk(rdy_dout == 0, "R2 line low on latch", rdy_dout, 0);
    read_word(got);
    chk(got == 18'h2A5C3, "R3 word msb first", got, 18'h2A5C3);
    chk(rdy_dout == 1, "R4 line holds bit 0 between edges", rdy_dout, 1);
    for (int i = 0; i < 6; i++) begin
      pulse(d);
      chk(d == 0, "R4 padding edge drives zero", d, 0);
    end
    pulse(d);
    chk(d == 1, "R5 25th edge releases line", d, 1);
    chk(conv_run == 1, "R5 still converting", conv_run, 1);

    give(18'h12345);
    give(18'h20001);
    read_word(got);
    chk(got == 18'h20001, "R7 newer result replaces unread", got, 18'h20001);
    give(18'h3FFFE);
    read_word(got);
    chk(got == 18'h3FFFE, "R3 negative word", got, 18'h3FFFE);

    give(18'h0F0F0);
    pulses(26);
    chk(cal_req == 1 && rdy_dout == 1, "R6 26th pulse starts cal", {cal_req, rdy_dout}, 2'b11);
    give(18'h11111);
    chk(rdy_dout == 1, "R11 strobe during cal ignored", rdy_dout, 1);
    finish_cal();
    chk(rdy_dout == 1 && conv_run == 1, "R6 high until post-cal result", {rdy_dout, conv_run}, 2'b11);
    give(18'h00ABC);
    chk(rdy_dout == 0, "R6 low on post-cal result", rdy_dout, 0);

    pulses(5);
    sclk = 1'b1; wait_clk(SC + 10);
    chk(rdy_dout == 1 && conv_run == 0 && cal_req == 0, "R8 partial read then sleep",
        {rdy_dout, conv_run, cal_req}, 3'b100);
    give(18'h22222);
    chk(rdy_dout == 1, "R11 strobe during sleep ignored", rdy_dout, 1);
    sclk = 1'b0; wait_clk(6);
    chk(conv_run == 1 && cal_req == 0 && rdy_dout == 1, "R9 wake resumes converting",
        {conv_run, cal_req, rdy_dout}, 3'b101);

    give(18'h15555);
    sclk = 1'b1; wait_clk(SC - 20); sclk = 1'b0; wait_clk(6);
    chk(conv_run == 1, "R8 short high is no sleep", conv_run, 1);
    chk(rdy_dout == 0, "R3 first bit of 0x15555 after long phase", rdy_dout, 0);

    give(18'h3C3C3);
    pulses(25);
    sclk = 1'b1; wait_clk(6);
    chk(cal_req == 0 && rdy_dout == 1, "R10 26th held high no cal yet", {cal_req, rdy_dout}, 2'b01);
    wait_clk(SC + 10);
    chk(conv_run == 0 && cal_req == 0, "R10 asleep after 26th", {conv_run, cal_req}, 2'b00);
    sclk = 1'b0; wait_clk(6);
    chk(cal_req == 1, "R10 wake runs calibration", cal_req, 1);
    finish_cal();
    give(18'h00001);
    read_word(got);
    chk(got == 18'h00001, "R3 word after wake calibration", got, 18'h00001);
    wait_clk(10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule